// File: doc/BRIEF.md
# Segmented Address Decoder for a Console Memory Map

This block sits between a 32-bit processor core and its memories and peripherals. For each request it works out which target the access belongs to and what offset to present there. The request is tagged as a read or a write, and as an instruction fetch or a data access. The top three address bits name a segment. A segment-dependent mask removes the cached and uncached window bits to give a physical address. The physical address is then classified against the map:

- a 2 MB main RAM that repeats through the lowest 8 MB;
- a 512 KB read-only boot ROM at 0x1FC00000;
- a 1 KB data scratchpad at the foot of the 64 KB hardware page at 0x1F800000;
- the I/O window that fills the rest of that page.

An access that fits no region gets an error response.

Three rules depend on the access itself. The scratchpad cannot be reached through the uncached segment (code 5); such an access falls through to the I/O path. Instruction fetches from the scratchpad are refused. While the cache-isolation input is high, writes bound for main RAM are sent to the instruction cache instead.

The result is registered. A small response state machine has three states: `ST_IDLE` (no response), `ST_HIT` (routed response) and `ST_FAULT` (error response). From every state, a cycle with a request moves the machine to `ST_HIT` or `ST_FAULT` according to the decode. A cycle without one returns it to `ST_IDLE`. The response is therefore presented exactly one cycle after the request.

Top module: `memmap_decoder`

## Requirements
- R1: After reset `rsp_valid` and `rsp_err` are 0. `rsp_valid` is 1 in the cycle after each cycle with `req_valid` high, and 0 in the cycle after each cycle with `req_valid` low.
- R2: Segment codes 0–3 and 6–7 pass the address through unchanged. Code 4 clears bit 31, and code 5 clears bits 31:29. So 0x00012344, 0x80012344 and 0xA0012344 all reach RAM offset 0x12344.
- R3: A physical address below 0x00800000 selects RAM (target code 1) with offset = physical address AND 0x1FFFFF.
- R4: A physical address in 0x1FC00000–0x1FC7FFFF selects the boot ROM (target code 2) with offset = physical address AND 0x7FFFF. Both fetches and data reads are accepted.
- R5: A write to the boot ROM is routed there with `rsp_wr_en` = 0 and `rsp_err` = 0.
- R6: A data access in segments other than 5 to physical 0x1F800000–0x1F8003FF selects the scratchpad (target code 3) with offset = address bits 9:0.
- R7: The same scratchpad range reached through segment 5 selects I/O (target code 4) instead.
- R8: An instruction fetch that would reach the scratchpad gives an error.
- R9: Any other physical address in 0x1F800000–0x1F80FFFF selects I/O (target code 4). For I/O the offset is the full, unmasked request address.
- R10: While `cache_iso` is 1, a write bound for RAM goes to the instruction cache (target code 5) with the RAM offset and `rsp_wr_en` = 1. Reads, and writes to other regions, are not redirected.
- R11: An unmapped physical address, including every segment-6/7 address, gives `rsp_err` = 1, target code 0, offset 0 and `rsp_wr_en` = 0.
- R12: `rsp_wr_en` equals `req_write` for RAM, instruction cache, scratchpad and I/O responses, and is 0 for every read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Virtual address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cache_iso | input | 1 | Cache-isolation status |
| rsp_valid | output | 1 | Registered response present |
| rsp_target | output | 3 | 0 none, 1 RAM, 2 boot ROM, 3 scratchpad, 4 I/O, 5 instruction cache |
| rsp_offset | output | 32 | Region offset, or full virtual address for I/O |
| rsp_wr_en | output | 1 | Write enable after region permissions |
| rsp_err | output | 1 | Error response |

## Verification
The bench targets the mask edges: the same offset through three segments, the last RAM mirror, and the first address past RAM and past the boot ROM. A wrong mask would send segment-4/5 addresses to error, or mirror at the wrong period. It drives the scratchpad through the uncached segment and as a fetch. A design that ignored the segment would return scratchpad data where I/O is due, and one that ignored the fetch tag would let code run from the scratchpad. Isolated writes, isolated reads and isolated scratchpad writes are mixed. This catches a redirect that is missing, or one that wrongly captures reads or other regions. Boot-ROM writes are checked for a cleared write enable with no error raised.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_RAM    = 3'd1,
        TGT_BIOS   = 3'd2,
        TGT_SPAD   = 3'd3,
        TGT_IO     = 3'd4,
        TGT_ICACHE = 3'd5
    } target_e;

    typedef struct packed {
        target_e     tgt;
        logic [31:0] off;
        logic        we;
        logic        err;
    } route_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIT   = 2'd1,
        ST_FAULT = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/mm_seg_strip.sv
module mm_seg_strip #(
    parameter int AW      = 32,
    parameter int SEG_W   = 3,
    parameter int K0_CODE = 4,
    parameter int K1_CODE = 5,
    parameter int K0_KEEP = 31,
    parameter int K1_KEEP = 29
) (
    input  logic [AW-1:0]    vaddr,
    output logic [SEG_W-1:0] seg,
    output logic [AW-1:0]    paddr
);
    localparam logic [AW-1:0] ONE     = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] K0_MASK = (ONE << K0_KEEP) - ONE;
    localparam logic [AW-1:0] K1_MASK = (ONE << K1_KEEP) - ONE;

    assign seg = vaddr[AW-1 -: SEG_W];

    always_comb begin
        if (seg == SEG_W'(K0_CODE))
            paddr = vaddr & K0_MASK;
        else if (seg == SEG_W'(K1_CODE))
            paddr = vaddr & K1_MASK;
        else
            paddr = vaddr;
    end
endmodule

// File: rtl/mm_region_map.sv
module mm_region_map
    import memmap_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          SEG_W      = 3,
    parameter int          UNCACHED   = 5,
    parameter int          RAM_AW     = 21,
    parameter int          RAM_WIN_AW = 23,
    parameter logic [31:0] BIOS_BASE  = 32'h1FC0_0000,
    parameter int          BIOS_AW    = 19,
    parameter logic [31:0] PAGE_BASE  = 32'h1F80_0000,
    parameter int          PAGE_AW    = 16,
    parameter int          SPAD_AW    = 10
) (
    input  logic [AW-1:0]    vaddr,
    input  logic [AW-1:0]    paddr,
    input  logic [SEG_W-1:0] seg,
    input  logic             write,
    input  logic             ifetch,
    input  logic             iso,
    output route_t           route
);
    localparam logic [AW-1:0] ONE       = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] RAM_MASK  = (ONE << RAM_AW) - ONE;
    localparam logic [AW-1:0] BIOS_MASK = (ONE << BIOS_AW) - ONE;
    localparam logic [AW-1:0] SPAD_MASK = (ONE << SPAD_AW) - ONE;
    localparam logic [AW-1:0] BIOS_TAG  = AW'(BIOS_BASE) >> BIOS_AW;
    localparam logic [AW-1:0] PAGE_TAG  = AW'(PAGE_BASE) >> PAGE_AW;

    logic ram_hit, bios_hit, page_hit, spad_hit, via_uncached;

    assign ram_hit      = (paddr >> RAM_WIN_AW) == '0;
    assign bios_hit     = (paddr >> BIOS_AW) == BIOS_TAG;
    assign page_hit     = (paddr >> PAGE_AW) == PAGE_TAG;
    assign spad_hit     = page_hit && ((paddr & ~SPAD_MASK) == (AW'(PAGE_BASE)));
    assign via_uncached = (seg == SEG_W'(UNCACHED));

    always_comb begin
        route = '{tgt: TGT_NONE, off: '0, we: 1'b0, err: 1'b1};
        if (ram_hit) begin
            route.err = 1'b0;
            route.off = paddr & RAM_MASK;
            route.we  = write;
            route.tgt = (write && iso) ? TGT_ICACHE : TGT_RAM;
        end else if (bios_hit) begin
            route.err = 1'b0;
            route.tgt = TGT_BIOS;
            route.off = paddr & BIOS_MASK;
        end else if (spad_hit && !via_uncached) begin
            if (!ifetch) begin
                route.err = 1'b0;
                route.tgt = TGT_SPAD;
                route.off = paddr & SPAD_MASK;
                route.we  = write;
            end
        end else if (page_hit) begin
            route.err = 1'b0;
            route.tgt = TGT_IO;
            route.off = vaddr;
            route.we  = write;
        end
    end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_ifetch,
    input  logic          cache_iso,
    output logic          rsp_valid,
    output logic [2:0]    rsp_target,
    output logic [31:0]   rsp_offset,
    output logic          rsp_wr_en,
    output logic          rsp_err
);
    localparam int SEG_W = 3;

    logic [SEG_W-1:0] seg;
    logic [AW-1:0]    paddr;
    route_t           route, held;
    rsp_state_e       state, state_nx;

    mm_seg_strip #(.AW(AW), .SEG_W(SEG_W)) i_strip (
        .vaddr (req_addr),
        .seg   (seg),
        .paddr (paddr)
    );

    mm_region_map #(.AW(AW), .SEG_W(SEG_W)) i_map (
        .vaddr  (req_addr),
        .paddr  (paddr),
        .seg    (seg),
        .write  (req_write),
        .ifetch (req_ifetch),
        .iso    (cache_iso),
        .route  (route)
    );

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_HIT, ST_FAULT: begin
                if (req_valid)
                    state_nx = route.err ? ST_FAULT : ST_HIT;
                else
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '{tgt: TGT_NONE, off: '0, we: 1'b0, err: 1'b0};
        else if (req_valid)
            held <= route;
    end

    always_comb begin
        rsp_valid  = 1'b0;
        rsp_err    = 1'b0;
        rsp_wr_en  = 1'b0;
        rsp_target = TGT_NONE;
        rsp_offset = '0;
        unique case (state)
            ST_IDLE: ;
            ST_HIT: begin
                rsp_valid  = 1'b1;
                rsp_target = held.tgt;
                rsp_offset = held.off;
                rsp_wr_en  = held.we;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R11
    err_has_no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_target == TGT_NONE && !rsp_wr_en && rsp_offset == '0));
    // R5
    bios_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_target == TGT_BIOS) |-> !rsp_wr_en);
    // R8
    no_fetch_from_spad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ifetch) |=> rsp_target != TGT_SPAD);
    // R10
    icache_needs_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(cache_iso && req_write)) |=> rsp_target != TGT_ICACHE);
    // R12
    read_never_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !rsp_wr_en);
endmodule

// File: tb/test_memmap_decoder.sv
module test_memmap_decoder;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [2:0]  tgt;
        logic [31:0] off;
        logic        we;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_ifetch = 1'b0;
    logic        cache_iso = 1'b0;
    logic        rsp_valid, rsp_wr_en, rsp_err;
    logic [2:0]  rsp_target;
    logic [31:0] rsp_offset;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    memmap_decoder i_memmap_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_ifetch(req_ifetch), .cache_iso(cache_iso),
        .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_offset(rsp_offset),
        .rsp_wr_en(rsp_wr_en), .rsp_err(rsp_err)
    );

    task automatic send(input logic [31:0] a, input logic w, input logic f, input logic iso,
                        input logic [2:0] t, input logic [31:0] o, input logic we,
                        input logic e, input string tag);
        exp_t x;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_ifetch = f; cache_iso = iso;
        x.tgt = t; x.off = o; x.we = we; x.err = e; x.tag = tag;
        sb.push_back(x);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compares each response with the oldest expected item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && rsp_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected response: actual valid=1 expected valid=0");
                end else begin
                    exp_t x;
                    x = sb.pop_front();
                    if (rsp_target !== x.tgt || rsp_offset !== x.off ||
                        rsp_wr_en !== x.we || rsp_err !== x.err) begin
                        fails++;
                        $display("FAIL %s actual tgt=%0d off=%h we=%b err=%b expected tgt=%0d off=%h we=%b err=%b",
                                 x.tag, rsp_target, rsp_offset, rsp_wr_en, rsp_err,
                                 x.tgt, x.off, x.we, x.err);
                    end
                end
            end else if (rst_n && sb.size() != 0) begin
                checks++;
                fails++;
                $display("FAIL R1 missing response: actual valid=0 expected valid=1 (%s)", sb[0].tag);
                void'(sb.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state: actual valid=%b err=%b expected 0 0", rsp_valid, rsp_err);
        end
        rst_n = 1'b1;

        // R2 same RAM offset through three segments
        send(32'h0001_2344, 0, 0, 0, 3'd1, 32'h0001_2344, 0, 0, "R2 kuseg");
        send(32'h8001_2344, 0, 0, 0, 3'd1, 32'h0001_2344, 0, 0, "R2 kseg0");
        send(32'hA001_2344, 0, 1, 0, 3'd1, 32'h0001_2344, 0, 0, "R2 kseg1");
        idle();
        // R3 mirroring
        send(32'h0061_2344, 0, 0, 0, 3'd1, 32'h0001_2344, 0, 0, "R3 mirror3");
        send(32'h807F_FFFC, 0, 0, 0, 3'd1, 32'h001F_FFFC, 0, 0, "R3 last word");
        send(32'h0020_0010, 1, 0, 0, 3'd1, 32'h0000_0010, 1, 0, "R12 ram write");
        // R4 boot ROM
        send(32'hBFC0_0100, 0, 0, 0, 3'd2, 32'h0000_0100, 0, 0, "R4 rom read");
        send(32'h9FC7_FFFC, 0, 1, 0, 3'd2, 32'h0007_FFFC, 0, 0, "R4 rom fetch top");
        send(32'h1FC8_0000, 0, 0, 0, 3'd0, 32'h0, 0, 1, "R11 past rom");
        // R5 ROM write suppressed
        send(32'hBFC0_0010, 1, 0, 0, 3'd2, 32'h0000_0010, 0, 0, "R5 rom write");
        idle();
        idle();
        // R6 scratchpad
        send(32'h1F80_03FC, 1, 0, 0, 3'd3, 32'h0000_03FC, 1, 0, "R6 spad write");
        send(32'h9F80_0004, 0, 0, 0, 3'd3, 32'h0000_0004, 0, 0, "R6 spad kseg0");
        // R7 uncached scratchpad -> I/O
        send(32'hBF80_0010, 0, 0, 0, 3'd4, 32'hBF80_0010, 0, 0, "R7 spad via kseg1");
        // R8 fetch from scratchpad
        send(32'h1F80_0020, 0, 1, 0, 3'd0, 32'h0, 0, 1, "R8 spad fetch");
        // R9 I/O window
        send(32'h1F80_1070, 1, 0, 0, 3'd4, 32'h1F80_1070, 1, 0, "R9 io write");
        send(32'h9F80_1810, 0, 0, 0, 3'd4, 32'h9F80_1810, 0, 0, "R9 io read");
        send(32'h1F80_0400, 0, 0, 0, 3'd4, 32'h1F80_0400, 0, 0, "R9 io first");
        // R10 cache isolation
        send(32'h0000_0100, 1, 0, 1, 3'd5, 32'h0000_0100, 1, 0, "R10 iso write");
        send(32'h0000_0100, 0, 0, 1, 3'd1, 32'h0000_0100, 0, 0, "R10 iso read");
        send(32'h1F80_0010, 1, 0, 1, 3'd3, 32'h0000_0010, 1, 0, "R10 iso spad write");
        send(32'h8000_0200, 1, 0, 0, 3'd1, 32'h0000_0200, 1, 0, "R10 no iso write");
        // R11 unmapped
        send(32'h0080_0000, 0, 0, 0, 3'd0, 32'h0, 0, 1, "R11 past ram");
        send(32'hC000_0000, 0, 0, 0, 3'd0, 32'h0, 0, 1, "R11 kseg2");
        send(32'hFFFE_0130, 1, 0, 0, 3'd0, 32'h0, 0, 1, "R11 kseg2 write");
        send(32'h1F81_0000, 0, 0, 0, 3'd0, 32'h0, 0, 1, "R11 past page");
        send(32'h2000_0000, 0, 0, 0, 3'd0, 32'h0, 0, 1, "R11 kuseg high");
        idle();
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1 outstanding: actual %0d expected 0", sb.size());
        end
        finish_run();
    end
endmodule